// File: doc/BRIEF.md
# SPI Slave Command Protocol Handler

This block sits between a byte-level SPI slave shifter and two byte buffers inside a host bridge. One buffer, the upstream buffer, carries bytes from the SPI bus toward the host. The other, the downstream buffer, carries bytes from the host toward the SPI bus. The handler reads the first byte of each chip-select frame as a command. It then answers length queries, stores or supplies data bytes, and tracks whether the external master has opened a session with the four-byte notification pattern.

The shifter gives the handler three things: a one-cycle strobe with each received byte, a one-cycle load request at the start of each outgoing byte slot, and the select level. In the same cycle as the load request, the handler presents the byte to send. The downstream buffer is first-word-fall-through: its head byte is visible and is removed by a pop strobe. The upstream buffer reports its free space and accepts a write strobe. A finalize request puts the handler back to waiting for a command. A reset request does the same and also emits a buffer-clear pulse.

Top module: `spi_cmd_handler`

## Requirements
- R1: Frames are bounded by the select line. A rising edge of `scs_n` returns the handler to waiting for a command from any state. The first byte received in the next frame is decoded as a command.
- R2: Command 0xA3 makes the tx byte of the very next slot equal the upstream free space, saturated at 128.
- R3: Command 0xA4 makes the tx byte of the very next slot equal the downstream fill level, saturated at 128.
- R4: After command 0xA5, every received byte in the same frame is written to the upstream buffer with its value unchanged. No write is issued when the upstream free space is zero.
- R5: After command 0xA6, each later byte slot of the frame presents the downstream head byte on `tx_byte` and pops exactly one byte.
- R6: During a 0xA6 frame, a slot that finds the downstream buffer empty sends 0x00 and does not pop.
- R7: Received bytes 0xA0, 0x7F, 0x5A, 0xA8 as the first four bytes of one frame toggle `session_open`. The first such frame sets it and the next clears it.
- R8: An unknown command byte, a broken notification pattern, or a pattern split over two frames is ignored until `scs_n` rises. No write occurs, no pop occurs, `session_open` keeps its value, and the tx byte is 0x00.
- R9: `sdo_en` is 0 whenever `scs_n` is high and 1 while it is low.
- R10: `finalize` returns the handler to waiting for a command and clears `session_open`. `reset_req` does the same and also raises `buf_clear` for exactly the next cycle.
- R11: After reset, `session_open`, `up_wr`, `dn_rd`, `buf_clear` and `tx_byte` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scs_n | input | 1 | Select level from the shifter, low inside a frame |
| rx_valid | input | 1 | One-cycle strobe: a byte was received |
| rx_byte | input | 8 | Received byte |
| tx_load | input | 1 | One-cycle request for the byte of the next slot |
| tx_byte | output | 8 | Byte to send, valid while tx_load is high |
| sdo_en | output | 1 | Serial output drive enable |
| up_space | input | UP_CW | Free entries in the upstream buffer |
| up_wr | output | 1 | Upstream write strobe |
| up_wdata | output | 8 | Upstream write data |
| dn_level | input | DN_CW | Filled entries in the downstream buffer |
| dn_rdata | input | 8 | Head byte of the downstream buffer |
| dn_rd | output | 1 | Downstream pop strobe |
| finalize | input | 1 | Return to waiting for a command |
| reset_req | input | 1 | Return to waiting for a command and clear the buffers |
| buf_clear | output | 1 | One-cycle buffer clear pulse |
| session_open | output | 1 | Session opened by a notification frame |

## Verification
The bench checks the length reply at and above the 128 saturation point, and at zero. A handler that skipped saturation would report 200 or 250. A handler that mistimed the reply would send it one slot late. The bench runs a data write into a nearly full upstream buffer and a data read that drains the downstream buffer partway through the frame. A design without the guards would overflow, pop an empty buffer, or send stale bytes in place of 0x00. The bench also tries notification patterns that are broken or split across frames, an aborted read followed by a fresh command, and finalize in the middle of a frame. A handler that kept state across the select edge would toggle the session falsely or treat data as commands.

// File: rtl/sch_pkg.sv
// Shared types and command codes of the SPI slave command handler.
package sch_pkg;
    typedef enum logic [2:0] {
        ST_CMD,   // waiting for the command byte of the frame
        ST_RESP,  // length reply goes out in the next slot
        ST_WR,    // bus bytes go to the upstream buffer
        ST_RD,    // downstream bytes go onto the bus
        ST_N1,    // notification: expecting the second pattern byte
        ST_N2,    // notification: expecting the third pattern byte
        ST_N3,    // notification: expecting the last pattern byte
        ST_SKIP   // rest of frame ignored
    } sch_state_t;

    localparam logic [7:0] OP_NOTE  = 8'hA0;
    localparam logic [7:0] OP_UPLEN = 8'hA3;
    localparam logic [7:0] OP_DNLEN = 8'hA4;
    localparam logic [7:0] OP_WRITE = 8'hA5;
    localparam logic [7:0] OP_READ  = 8'hA6;
    localparam logic [7:0] PAT_1    = 8'h7F;
    localparam logic [7:0] PAT_2    = 8'h5A;
    localparam logic [7:0] PAT_3    = 8'hA8;
endpackage

// File: rtl/sch_fsm.sv
// Frame state machine: decodes the command byte, follows the notification
// pattern and owns the session flag and the buffer-clear pulse.
// Assumes scs_n, rx_valid and tx_load are already synchronous to clk.
module sch_fsm
    import sch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scs_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       tx_load,
    input  logic       finalize,
    input  logic       reset_req,
    output sch_state_t state,
    output logic       len_load,
    output logic       len_sel_up,
    output logic       session_open,
    output logic       buf_clear
);
    sch_state_t nxt;
    logic       toggle;

    // Next-state decode for one received byte or slot.
    always_comb begin
        nxt    = state;
        toggle = 1'b0;
        case (state)
            ST_CMD: if (rx_valid) begin
                case (rx_byte)
                    OP_UPLEN, OP_DNLEN: nxt = ST_RESP;
                    OP_WRITE:           nxt = ST_WR;
                    OP_READ:            nxt = ST_RD;
                    OP_NOTE:            nxt = ST_N1;
                    default:            nxt = ST_SKIP;
                endcase
            end
            ST_RESP: if (tx_load) nxt = ST_SKIP;
            ST_N1: if (rx_valid) nxt = (rx_byte == PAT_1) ? ST_N2 : ST_SKIP;
            ST_N2: if (rx_valid) nxt = (rx_byte == PAT_2) ? ST_N3 : ST_SKIP;
            ST_N3: if (rx_valid) begin
                nxt    = ST_SKIP;
                toggle = (rx_byte == PAT_3);
            end
            default: nxt = state;
        endcase
    end

    // Length capture happens with the query command byte.
    assign len_load   = (state == ST_CMD) && rx_valid && !scs_n &&
                        (rx_byte == OP_UPLEN || rx_byte == OP_DNLEN);
    assign len_sel_up = (rx_byte == OP_UPLEN);

    // State, session flag and clear pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_CMD;
            session_open <= 1'b0;
            buf_clear    <= 1'b0;
        end else begin
            buf_clear <= reset_req;
            if (reset_req || finalize) begin
                state        <= ST_CMD;
                session_open <= 1'b0;
            end else if (scs_n) begin
                state <= ST_CMD;
            end else begin
                state <= nxt;
                if (toggle) session_open <= ~session_open;
            end
        end
    end
endmodule

// File: rtl/sch_len_sat.sv
// Captures the saturated fill or free count of the selected buffer when a
// length query is decoded, so the reply cannot move during its slot.
// Assumes LEN_MAX fits in one byte.
module sch_len_sat #(
    parameter int UP_CW   = 9,
    parameter int DN_CW   = 9,
    parameter int LEN_MAX = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             sel_up,
    input  logic [UP_CW-1:0] up_cnt,
    input  logic [DN_CW-1:0] dn_cnt,
    output logic [7:0]       len_q
);
    localparam logic [31:0] LIM = 32'(LEN_MAX);

    logic [31:0] raw;
    logic [7:0]  sat;

    // Widen the chosen count and clamp it to the reply limit.
    always_comb begin
        raw = sel_up ? 32'(up_cnt) : 32'(dn_cnt);
        sat = (raw > LIM) ? LIM[7:0] : raw[7:0];
    end

    // Hold the reply byte.
    always_ff @(posedge clk) begin
        if (!rst_n)    len_q <= 8'h00;
        else if (load) len_q <= sat;
    end
endmodule

// File: rtl/sch_tx_path.sv
// Byte movement: selects the byte for each outgoing slot, issues the pops
// and writes of the buffers, and gates the serial output drive.
// Assumes the downstream buffer shows its head byte before the pop.
module sch_tx_path
    import sch_pkg::*;
#(
    parameter int UP_CW = 9,
    parameter int DN_CW = 9
) (
    input  sch_state_t       state,
    input  logic             scs_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             tx_load,
    input  logic [7:0]       len_q,
    input  logic [UP_CW-1:0] up_space,
    input  logic [DN_CW-1:0] dn_level,
    input  logic [7:0]       dn_rdata,
    output logic [7:0]       tx_byte,
    output logic             dn_rd,
    output logic             up_wr,
    output logic [7:0]       up_wdata,
    output logic             sdo_en
);
    logic rd_avail;

    assign rd_avail = (dn_level != '0);
    assign sdo_en   = ~scs_n;

    // Slot byte selection: the reply, the buffer head, or filler 0x00.
    always_comb begin
        case (state)
            ST_RESP: tx_byte = len_q;
            ST_RD:   tx_byte = rd_avail ? dn_rdata : 8'h00;
            default: tx_byte = 8'h00;
        endcase
    end

    // Buffer strobes, guarded against an empty source or full sink.
    assign dn_rd    = tx_load && !scs_n && (state == ST_RD) && rd_avail;
    assign up_wr    = rx_valid && !scs_n && (state == ST_WR) && (up_space != '0);
    assign up_wdata = rx_byte;
endmodule

// File: rtl/spi_cmd_handler.sv
// Top of the SPI slave command handler. Joins the frame state machine, the
// length capture and the byte path. Assumes one byte strobe per slot and a
// tx_load that comes after the rx strobe of the slot before.
module spi_cmd_handler
    import sch_pkg::*;
#(
    parameter int UP_CW   = 9,
    parameter int DN_CW   = 9,
    parameter int LEN_MAX = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scs_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             tx_load,
    output logic [7:0]       tx_byte,
    output logic             sdo_en,
    input  logic [UP_CW-1:0] up_space,
    output logic             up_wr,
    output logic [7:0]       up_wdata,
    input  logic [DN_CW-1:0] dn_level,
    input  logic [7:0]       dn_rdata,
    output logic             dn_rd,
    input  logic             finalize,
    input  logic             reset_req,
    output logic             buf_clear,
    output logic             session_open
);
    sch_state_t st;
    logic       len_load;
    logic       len_sel_up;
    logic [7:0] len_q;

    sch_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .scs_n(scs_n),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_load(tx_load),
        .finalize(finalize), .reset_req(reset_req),
        .state(st), .len_load(len_load), .len_sel_up(len_sel_up),
        .session_open(session_open), .buf_clear(buf_clear)
    );

    sch_len_sat #(.UP_CW(UP_CW), .DN_CW(DN_CW), .LEN_MAX(LEN_MAX)) u_len (
        .clk(clk), .rst_n(rst_n), .load(len_load), .sel_up(len_sel_up),
        .up_cnt(up_space), .dn_cnt(dn_level), .len_q(len_q)
    );

    sch_tx_path #(.UP_CW(UP_CW), .DN_CW(DN_CW)) u_path (
        .state(st), .scs_n(scs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_load(tx_load), .len_q(len_q), .up_space(up_space),
        .dn_level(dn_level), .dn_rdata(dn_rdata), .tx_byte(tx_byte),
        .dn_rd(dn_rd), .up_wr(up_wr), .up_wdata(up_wdata), .sdo_en(sdo_en)
    );
endmodule

// File: rtl/sch_chk.sv
// Protocol checker bound to the handler top; observes ports only.
module sch_chk #(
    parameter int UP_CW   = 9,
    parameter int DN_CW   = 9,
    parameter int LEN_MAX = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scs_n,
    input logic             rx_valid,
    input logic [7:0]       rx_byte,
    input logic             tx_load,
    input logic [7:0]       tx_byte,
    input logic             sdo_en,
    input logic [UP_CW-1:0] up_space,
    input logic             up_wr,
    input logic [7:0]       up_wdata,
    input logic [DN_CW-1:0] dn_level,
    input logic [7:0]       dn_rdata,
    input logic             dn_rd,
    input logic             finalize,
    input logic             reset_req,
    input logic             buf_clear,
    input logic             session_open
);
    // R6
    no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_rd |-> (dn_level != '0));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_wr |-> (!scs_n && up_space != '0 && up_wdata == rx_byte));

    // R5
    pop_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_rd |-> (tx_byte == dn_rdata && tx_load));

    // R2 R3
    len_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && !dn_rd) |-> (32'(tx_byte) <= 32'(LEN_MAX)));

    // R7 R10
    session_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(session_open) |->
            ($past(reset_req) || $past(finalize) ||
             ($past(rx_valid) && $past(rx_byte) == 8'hA8)));

    // R10
    clear_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> buf_clear);

    // R1
    idle_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scs_n |-> (!up_wr && !dn_rd));
endmodule

bind spi_cmd_handler sch_chk #(.UP_CW(UP_CW), .DN_CW(DN_CW), .LEN_MAX(LEN_MAX)) u_chk (.*);

// File: tb/spi_cmd_handler_tb.sv
module spi_cmd_handler_tb;
    localparam int CLK_P = 10;
    localparam int UP_CW = 9;
    localparam int DN_CW = 9;

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] nb;     // data slots after the command
        logic [8:0] up;     // upstream free space
        logic [8:0] dn;     // downstream fill
        logic [7:0] resp;   // expected tx of slot 1
        logic       rchk;   // slot 1 tx is checked
        logic [7:0] wr;     // expected writes
        logic [7:0] pop;    // expected pops
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{8'hA3, 8'd1, 9'd200, 9'd0,   8'd128, 1'b1, 8'd0, 8'd0},  // R2 sat
        '{8'hA3, 8'd1, 9'd37,  9'd0,   8'd37,  1'b1, 8'd0, 8'd0},  // R2
        '{8'hA3, 8'd1, 9'd0,   9'd0,   8'd0,   1'b1, 8'd0, 8'd0},  // R2 zero
        '{8'hA4, 8'd1, 9'd0,   9'd5,   8'd5,   1'b1, 8'd0, 8'd0},  // R3
        '{8'hA4, 8'd1, 9'd0,   9'd250, 8'd128, 1'b1, 8'd0, 8'd0},  // R3 sat
        '{8'hA5, 8'd3, 9'd10,  9'd0,   8'd0,   1'b1, 8'd3, 8'd0},  // R4
        '{8'hA5, 8'd3, 9'd2,   9'd0,   8'd0,   1'b1, 8'd2, 8'd0},  // R4 full
        '{8'hA6, 8'd3, 9'd0,   9'd5,   8'h40,  1'b1, 8'd0, 8'd3},  // R5
        '{8'hA6, 8'd3, 9'd0,   9'd1,   8'h40,  1'b1, 8'd0, 8'd1},  // R6
        '{8'h55, 8'd2, 9'd10,  9'd5,   8'd0,   1'b1, 8'd0, 8'd0}   // R8
    };

    logic clk = 0, rst_n = 0, scs_n = 1, rx_valid = 0, tx_load = 0;
    logic finalize = 0, reset_req = 0, clr = 0;
    logic [7:0] rx_byte = 0;
    logic [8:0] up_init = 0, dn_init = 0;
    logic [7:0] wr_cnt, pop_cnt, last_wd;
    logic [UP_CW-1:0] up_space;
    logic [DN_CW-1:0] dn_level;
    logic [7:0] dn_rdata, tx_byte, up_wdata;
    logic sdo_en, up_wr, dn_rd, buf_clear, session_open;
    logic [7:0] fb [8];
    logic [7:0] txs [8];
    int checks = 0, errors = 0;

    always #(CLK_P/2) clk = ~clk;

    assign up_space = up_init - 9'(wr_cnt);
    assign dn_level = (dn_init > 9'(pop_cnt)) ? dn_init - 9'(pop_cnt) : 9'd0;
    assign dn_rdata = 8'h40 + pop_cnt;

    // Buffer-side models: count strobes, keep the last written byte.
    always @(posedge clk) begin
        if (clr) begin
            wr_cnt <= 0; pop_cnt <= 0; last_wd <= 0;
        end else begin
            if (up_wr) begin wr_cnt <= wr_cnt + 1; last_wd <= up_wdata; end
            if (dn_rd) pop_cnt <= pop_cnt + 1;
        end
    end

    spi_cmd_handler #(.UP_CW(UP_CW), .DN_CW(DN_CW), .LEN_MAX(128)) u_dut (
        .clk(clk), .rst_n(rst_n), .scs_n(scs_n), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_load(tx_load), .tx_byte(tx_byte),
        .sdo_en(sdo_en), .up_space(up_space), .up_wr(up_wr),
        .up_wdata(up_wdata), .dn_level(dn_level), .dn_rdata(dn_rdata),
        .dn_rd(dn_rd), .finalize(finalize), .reset_req(reset_req),
        .buf_clear(buf_clear), .session_open(session_open)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic prep(input logic [8:0] u, input logic [8:0] d);
        @(negedge clk); up_init = u; dn_init = d; clr = 1;
        @(negedge clk); clr = 0;
    endtask

    task automatic slot(input logic [7:0] b, output logic [7:0] t);
        @(negedge clk); tx_load = 1; #1 t = tx_byte;
        @(negedge clk); tx_load = 0; rx_valid = 1; rx_byte = b;
        @(negedge clk); rx_valid = 0;
    endtask

    task automatic open_frame();
        @(negedge clk); scs_n = 0;
        @(negedge clk);
    endtask

    task automatic close_frame();
        @(negedge clk); scs_n = 1;
        @(negedge clk);
    endtask

    task automatic frame(input int n);
        logic [7:0] t;
        open_frame();
        for (int i = 0; i < n; i++) begin slot(fb[i], t); txs[i] = t; end
        close_frame();
    endtask

    task automatic note(input logic [7:0] a, b, c, d);
        fb[0] = a; fb[1] = b; fb[2] = c; fb[3] = d;
        frame(4);
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clr = 1;
        repeat (3) @(negedge clk);
        rst_n = 1; clr = 0;
        @(negedge clk);
        // R11 reset state
        chk("R11 session", session_open, 0);
        chk("R11 up_wr", up_wr, 0);
        chk("R11 dn_rd", dn_rd, 0);
        chk("R11 buf_clear", buf_clear, 0);
        chk("R11 tx_byte", tx_byte, 0);
        // R9 drive off outside a frame
        chk("R9 sdo_en idle", sdo_en, 0);

        // Table walk: R2 R3 R4 R5 R6 R8
        for (int v = 0; v < NV; v++) begin
            prep(VEC[v].up, VEC[v].dn);
            fb[0] = VEC[v].cmd;
            for (int i = 1; i < 8; i++) fb[i] = 8'h10 + 8'(i);
            frame(1 + int'(VEC[v].nb));
            if (VEC[v].rchk) chk("R2/R3 slot1 tx", txs[1], VEC[v].resp);
            chk("R4 writes", wr_cnt, VEC[v].wr);
            chk("R5 pops", pop_cnt, VEC[v].pop);
            if (VEC[v].wr != 0) chk("R4 last data", last_wd, 8'h10 + VEC[v].wr);
            if (VEC[v].cmd == 8'hA6)
                for (int k = 1; k <= int'(VEC[v].nb); k++)
                    chk("R6 read slot", txs[k],
                        (9'(k - 1) < VEC[v].dn) ? 8'h40 + 8'(k - 1) : 8'h00);
            if (VEC[v].cmd == 8'h55) begin
                chk("R8 unknown tx", txs[1], 0);
                chk("R8 unknown tx2", txs[2], 0);
            end
        end

        // R9 drive on inside a frame
        prep(0, 0);
        open_frame();
        chk("R9 sdo_en frame", sdo_en, 1);
        close_frame();
        chk("R9 sdo_en after", sdo_en, 0);

        // R7 notification toggles session
        note(8'hA0, 8'h7F, 8'h5A, 8'hA8);
        chk("R7 open", session_open, 1);
        // R8 broken pattern leaves it
        note(8'hA0, 8'h7F, 8'h00, 8'hA8);
        chk("R8 broken", session_open, 1);
        // R8 pattern split across frames
        fb[0] = 8'hA0; fb[1] = 8'h7F; frame(2);
        fb[0] = 8'h5A; fb[1] = 8'hA8; frame(2);
        chk("R8 split", session_open, 1);
        note(8'hA0, 8'h7F, 8'h5A, 8'hA8);
        chk("R7 close", session_open, 0);

        // R1 aborted read, then a fresh length query
        begin
            logic [7:0] t;
            prep(20, 4);
            open_frame(); slot(8'hA6, t); slot(8'h00, t); close_frame();
            chk("R1 abort pops", pop_cnt, 1);
            open_frame(); slot(8'hA3, t); slot(8'h00, t); close_frame();
            chk("R1 fresh command", t, 20);
            chk("R1 no extra pop", pop_cnt, 1);
        end

        // R10 finalize mid write frame
        note(8'hA0, 8'h7F, 8'h5A, 8'hA8);
        chk("R7 reopen", session_open, 1);
        begin
            logic [7:0] t;
            prep(10, 0);
            open_frame(); slot(8'hA5, t); slot(8'h11, t);
            @(negedge clk); finalize = 1;
            @(negedge clk); finalize = 0;
            chk("R10 finalize session", session_open, 0);
            slot(8'h12, t); slot(8'h13, t);
            close_frame();
            chk("R10 finalize writes", wr_cnt, 1);
        end

        // R10 reset request pulse
        @(negedge clk); reset_req = 1;
        @(negedge clk); reset_req = 0;
        chk("R10 clear pulse", buf_clear, 1);
        @(negedge clk);
        chk("R10 clear ends", buf_clear, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule